// File: doc/BRIEF.md
# Backward Dataflow Slice Extractor

This block watches the stream of committed instructions and keeps a circular window of the most recent ones that can take part in address arithmetic. Integer ALU operations and loads are held. Stores, branches and floating-point operations pass by without taking a slot. For each held instruction it records a bit vector with one bit per window slot. The vector marks the slots whose instructions produced that instruction's source registers. A producer table with one entry per integer register supplies these links. It names the slot that last wrote each register, or says that no slot in the window holds the writer.

A candidate load is flagged on the same commit that inserts it. The window is then snapshotted into a shadow copy. The shadow copy is walked from the candidate towards older entries, one slot per cycle. The walk keeps a running vector: each entry whose bit is set joins the slice and adds its own producer bits. The result is the set of instructions that computed the load's address. They are presented oldest first, together with the count and the PC of the oldest retained instruction (the lead). The working window keeps taking one commit per cycle while the walk runs. Only one walk can be in flight, so a candidate flagged during a walk is discarded and counted.

Top module: `slice_extractor`

## Requirements
- R1: After reset, busy, slice_valid, slice_cnt and drop_cnt are all 0.
- R2: Only commits whose class is ALU (0) or LOAD (1) enter the window. Classes STORE (2), BRANCH (3) and FP (4) take no slot, so a window of N slots can span more than N commits.
- R3: For each valid source register, an instruction's producer is the most recent instruction still in the window that wrote that register. The slice contains the candidate load and, by transitive closure, all of its producers within the snapshot.
- R4: The window holds N entries (default 32). Inserting into a full window discards the oldest entry. Links to a discarded entry vanish, both in stored vectors and in the producer table, so later readers of its register get no producer.
- R5: slice_insn carries the slice oldest first: lane 0 (bits IW-1:0) is the lead, and lane slice_cnt-1 is the candidate load. Unused lanes read zero. slice_lead_pc is the PC of lane 0.
- R6: If more than MAXS (16) instructions are selected, only the MAXS youngest are kept. slice_cnt is then MAXS and the lead is the oldest kept instruction.
- R7: A trigger is accepted when cm_valid is 1, cm_class is LOAD, cand_trig is 1 and busy is 0. busy is 1 from the next cycle on. slice_valid pulses for exactly one cycle, starting N+2 cycles after the sampling edge of the trigger, and busy is 0 in that cycle.
- R8: Commits are taken every cycle during a walk, and they do not change the slice being extracted. Later slices see them as normal window contents.
- R9: A LOAD trigger that arrives while busy is 1 starts nothing and raises drop_cnt by one. drop_cnt changes on no other event.
- R10: cand_trig on a commit whose class is not LOAD is ignored: no walk starts and drop_cnt is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_valid | input | 1 | A commit is present this cycle |
| cm_pc | input | PCW | PC of the committing instruction |
| cm_insn | input | IW | Instruction word, stored as given |
| cm_class | input | 3 | 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH, 4 FP |
| cm_dst_vld | input | 1 | Instruction writes an integer register |
| cm_dst | input | log2(NREG) | Destination register number |
| cm_srca_vld | input | 1 | First source register is used |
| cm_srca | input | log2(NREG) | First source register number |
| cm_srcb_vld | input | 1 | Second source register is used |
| cm_srcb | input | log2(NREG) | Second source register number |
| cand_trig | input | 1 | This commit is a candidate load |
| busy | output | 1 | A slice walk is in flight |
| slice_valid | output | 1 | One-cycle pulse: slice outputs updated |
| slice_cnt | output | log2(MAXS+1) | Number of instructions in the slice |
| slice_lead_pc | output | PCW | PC of the oldest retained instruction |
| slice_insn | output | MAXS*IW | Slice words, lane 0 is the lead |
| drop_cnt | output | DCW | Number of triggers discarded while busy |

## Verification
A trigger is sampled at one rising edge. The shadow copy is loaded at the next edge, the N walk steps take the N edges after that, and the results are registered one edge later. slice_valid is therefore first seen N+2 edges after the trigger edge. The bench counts clock edges from the cycle in which it drove the trigger and samples on falling edges. It requires the pulse in exactly that cycle and checks busy in the cycle right after the trigger. The expected slice is computed when the trigger is driven, with a live-register backward scan over a model window. Commits issued later cannot change the expected values, and the count of discarded triggers is read at the port after the stimulus that should raise it.

// File: rtl/slx_pkg.sv
package slx_pkg;

    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_FP     = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_COPY = 2'd1,
        W_WALK = 2'd2,
        W_FIN  = 2'd3
    } wstate_e;

    // Only address-relevant classes occupy a window slot.
    function automatic logic is_tracked(input logic [2:0] c);
        return (c == CLS_ALU) || (c == CLS_LOAD);
    endfunction

    function automatic logic is_load(input logic [2:0] c);
        return c == CLS_LOAD;
    endfunction

endpackage

// File: rtl/slx_prod_tab.sv
module slx_prod_tab #(
    parameter int N    = 32,
    parameter int NREG = 32,
    localparam int SW  = $clog2(N),
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ins,
    input  logic [SW-1:0] ins_slot,
    input  logic          evict,
    input  logic          dst_vld,
    input  logic [RW-1:0] dst,
    input  logic          srca_vld,
    input  logic [RW-1:0] srca,
    input  logic          srcb_vld,
    input  logic [RW-1:0] srcb,
    output logic          a_hit,
    output logic [SW-1:0] a_slot,
    output logic          b_hit,
    output logic [SW-1:0] b_slot
);

    logic [NREG-1:0]         pt_v;
    logic [NREG-1:0][SW-1:0] pt_s;

    // A producer sitting in the slot being overwritten is no longer a producer.
    always_comb begin
        a_slot = pt_s[srca];
        b_slot = pt_s[srcb];
        a_hit  = srca_vld && pt_v[srca] && !(evict && (pt_s[srca] == ins_slot));
        b_hit  = srcb_vld && pt_v[srcb] && !(evict && (pt_s[srcb] == ins_slot));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_v <= '0;
            pt_s <= '0;
        end else if (ins) begin
            for (int r = 0; r < NREG; r++) begin
                if (evict && pt_v[r] && (pt_s[r] == ins_slot)) begin
                    pt_v[r] <= 1'b0;
                end
            end
            if (dst_vld) begin
                pt_v[dst] <= 1'b1;
                pt_s[dst] <= ins_slot;
            end
        end
    end

endmodule

// File: rtl/slx_history.sv
module slx_history #(
    parameter int N    = 32,
    parameter int NREG = 32,
    parameter int PCW  = 32,
    parameter int IW   = 32,
    localparam int SW  = $clog2(N),
    localparam int RW  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins,
    input  logic [PCW-1:0]         pc,
    input  logic [IW-1:0]          insn,
    input  logic                   dst_vld,
    input  logic [RW-1:0]          dst,
    input  logic                   srca_vld,
    input  logic [RW-1:0]          srca,
    input  logic                   srcb_vld,
    input  logic [RW-1:0]          srcb,
    output logic [SW-1:0]          wp,
    output logic [N-1:0]           h_v,
    output logic [N-1:0][PCW-1:0]  h_pc,
    output logic [N-1:0][IW-1:0]   h_insn,
    output logic [N-1:0][N-1:0]    h_dv
);

    logic          evict;
    logic          a_hit, b_hit;
    logic [SW-1:0] a_slot, b_slot;
    logic [N-1:0]  new_dv;

    assign evict = h_v[wp];

    slx_prod_tab #(.N(N), .NREG(NREG)) u_pt (
        .clk      (clk),
        .rst      (rst),
        .ins      (ins),
        .ins_slot (wp),
        .evict    (evict),
        .dst_vld  (dst_vld),
        .dst      (dst),
        .srca_vld (srca_vld),
        .srca     (srca),
        .srcb_vld (srcb_vld),
        .srcb     (srcb),
        .a_hit    (a_hit),
        .a_slot   (a_slot),
        .b_hit    (b_hit),
        .b_slot   (b_slot)
    );

    always_comb begin
        new_dv = '0;
        if (a_hit) new_dv[a_slot] = 1'b1;
        if (b_hit) new_dv[b_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp     <= '0;
            h_v    <= '0;
            h_pc   <= '0;
            h_insn <= '0;
            h_dv   <= '0;
        end else if (ins) begin
            // Column clear: nobody may keep pointing at the overwritten slot.
            for (int i = 0; i < N; i++) begin
                h_dv[i][wp] <= 1'b0;
            end
            h_dv[wp]   <= new_dv;
            h_v[wp]    <= 1'b1;
            h_pc[wp]   <= pc;
            h_insn[wp] <= insn;
            wp         <= wp + 1'b1;
        end
    end

endmodule

// File: rtl/slx_walker.sv
module slx_walker
    import slx_pkg::*;
#(
    parameter int N    = 32,
    parameter int PCW  = 32,
    parameter int IW   = 32,
    parameter int MAXS = 16,
    localparam int SW  = $clog2(N),
    localparam int CW  = $clog2(MAXS + 1),
    localparam int BW  = $clog2(MAXS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [SW-1:0]           start_slot,
    input  logic [N-1:0]            h_v,
    input  logic [N-1:0][PCW-1:0]   h_pc,
    input  logic [N-1:0][IW-1:0]    h_insn,
    input  logic [N-1:0][N-1:0]     h_dv,
    output logic                    busy,
    output logic                    done,
    output logic [CW-1:0]           cnt_o,
    output logic [PCW-1:0]          lead_o,
    output logic [MAXS-1:0][IW-1:0] res_o
);

    wstate_e                 st;
    logic [SW-1:0]           cand;
    logic [SW-1:0]           k;
    logic [N-1:0]            s_v;
    logic [N-1:0][PCW-1:0]   s_pc;
    logic [N-1:0][IW-1:0]    s_insn;
    logic [N-1:0][N-1:0]     s_dv;
    logic [N-1:0]            acc;
    logic [CW-1:0]           seln;
    logic [MAXS-1:0][IW-1:0] sbuf;
    logic [PCW-1:0]          lead;

    logic [SW-1:0] idx;
    logic          sel;
    logic [BW-1:0] pos;

    assign busy = (st != W_IDLE);
    assign idx  = cand - k;
    assign sel  = (k == '0) || (s_v[idx] && acc[idx]);
    assign pos  = BW'(MAXS - 1 - int'(seln));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= W_IDLE;
            cand   <= '0;
            k      <= '0;
            s_v    <= '0;
            s_pc   <= '0;
            s_insn <= '0;
            s_dv   <= '0;
            acc    <= '0;
            seln   <= '0;
            sbuf   <= '0;
            lead   <= '0;
            done   <= 1'b0;
            cnt_o  <= '0;
            lead_o <= '0;
            res_o  <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                W_IDLE: begin
                    if (start) begin
                        cand <= start_slot;
                        st   <= W_COPY;
                    end
                end
                W_COPY: begin
                    // The candidate was written at the trigger edge, so it is in the copy.
                    s_v    <= h_v;
                    s_pc   <= h_pc;
                    s_insn <= h_insn;
                    s_dv   <= h_dv;
                    acc    <= '0;
                    seln   <= '0;
                    sbuf   <= '0;
                    k      <= '0;
                    st     <= W_WALK;
                end
                W_WALK: begin
                    if (sel) begin
                        acc <= acc | s_dv[idx];
                        if (seln < CW'(MAXS)) begin
                            sbuf[pos] <= s_insn[idx];
                            lead      <= s_pc[idx];
                            seln      <= seln + 1'b1;
                        end
                    end
                    k <= k + 1'b1;
                    if (k == SW'(N - 1)) st <= W_FIN;
                end
                W_FIN: begin
                    for (int i = 0; i < MAXS; i++) begin
                        if (i < int'(seln)) begin
                            res_o[i] <= sbuf[BW'(i + MAXS - int'(seln))];
                        end else begin
                            res_o[i] <= '0;
                        end
                    end
                    cnt_o  <= seln;
                    lead_o <= lead;
                    done   <= 1'b1;
                    st     <= W_IDLE;
                end
                default: st <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/slice_extractor.sv
module slice_extractor
    import slx_pkg::*;
#(
    parameter int N    = 32,
    parameter int NREG = 32,
    parameter int PCW  = 32,
    parameter int IW   = 32,
    parameter int MAXS = 16,
    parameter int DCW  = 16,
    localparam int SW  = $clog2(N),
    localparam int RW  = $clog2(NREG),
    localparam int CW  = $clog2(MAXS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cm_valid,
    input  logic [PCW-1:0]      cm_pc,
    input  logic [IW-1:0]       cm_insn,
    input  logic [2:0]          cm_class,
    input  logic                cm_dst_vld,
    input  logic [RW-1:0]       cm_dst,
    input  logic                cm_srca_vld,
    input  logic [RW-1:0]       cm_srca,
    input  logic                cm_srcb_vld,
    input  logic [RW-1:0]       cm_srcb,
    input  logic                cand_trig,
    output logic                busy,
    output logic                slice_valid,
    output logic [CW-1:0]       slice_cnt,
    output logic [PCW-1:0]      slice_lead_pc,
    output logic [MAXS*IW-1:0]  slice_insn,
    output logic [DCW-1:0]      drop_cnt
);

    logic                    ins;
    logic                    trig_load;
    logic                    accept;
    logic [SW-1:0]           wp;
    logic [N-1:0]            h_v;
    logic [N-1:0][PCW-1:0]   h_pc;
    logic [N-1:0][IW-1:0]    h_insn;
    logic [N-1:0][N-1:0]     h_dv;
    logic [MAXS-1:0][IW-1:0] res;

    assign ins       = cm_valid && is_tracked(cm_class);
    assign trig_load = cm_valid && is_load(cm_class) && cand_trig;
    assign accept    = trig_load && !busy;

    slx_history #(.N(N), .NREG(NREG), .PCW(PCW), .IW(IW)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .ins      (ins),
        .pc       (cm_pc),
        .insn     (cm_insn),
        .dst_vld  (cm_dst_vld),
        .dst      (cm_dst),
        .srca_vld (cm_srca_vld),
        .srca     (cm_srca),
        .srcb_vld (cm_srcb_vld),
        .srcb     (cm_srcb),
        .wp       (wp),
        .h_v      (h_v),
        .h_pc     (h_pc),
        .h_insn   (h_insn),
        .h_dv     (h_dv)
    );

    slx_walker #(.N(N), .PCW(PCW), .IW(IW), .MAXS(MAXS)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_slot (wp),
        .h_v        (h_v),
        .h_pc       (h_pc),
        .h_insn     (h_insn),
        .h_dv       (h_dv),
        .busy       (busy),
        .done       (slice_valid),
        .cnt_o      (slice_cnt),
        .lead_o     (slice_lead_pc),
        .res_o      (res)
    );

    assign slice_insn = res;

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_cnt <= '0;
        end else if (trig_load && busy) begin
            drop_cnt <= drop_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/slx_chk.sv
module slx_chk #(
    parameter int MAXS = 16,
    parameter int CW   = 5,
    parameter int DCW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           cm_valid,
    input logic [2:0]     cm_class,
    input logic           cand_trig,
    input logic           busy,
    input logic           slice_valid,
    input logic [CW-1:0]  slice_cnt,
    input logic [DCW-1:0] drop_cnt
);

    logic trig_load;
    assign trig_load = cm_valid && (cm_class == 3'd1) && cand_trig;

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_load && !busy) |=> busy);

    // R7
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        slice_valid |=> !slice_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        slice_valid |-> !busy);

    // R9
    drop_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_load && busy) |=> (drop_cnt == $past(drop_cnt) + 1'b1));

    // R9
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(trig_load && busy) |=> $stable(drop_cnt));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        slice_valid |-> (slice_cnt >= CW'(1)) && (slice_cnt <= CW'(MAXS)));

    // R10
    nonload_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && cand_trig && (cm_class != 3'd1) && !busy) |=> !busy);

endmodule

bind slice_extractor slx_chk #(.MAXS(MAXS), .CW(CW), .DCW(DCW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cm_valid    (cm_valid),
    .cm_class    (cm_class),
    .cand_trig   (cand_trig),
    .busy        (busy),
    .slice_valid (slice_valid),
    .slice_cnt   (slice_cnt),
    .drop_cnt    (drop_cnt)
);

// File: tb/sim_slice_extractor.sv
`timescale 1ns/1ps
module sim_slice_extractor;

    localparam int N    = 32;
    localparam int NREG = 32;
    localparam int MAXS = 16;
    localparam int IW   = 32;
    localparam int PCW  = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cm_valid = 1'b0;
    logic [31:0]      cm_pc = '0;
    logic [31:0]      cm_insn = '0;
    logic [2:0]       cm_class = '0;
    logic             cm_dst_vld = 1'b0;
    logic [4:0]       cm_dst = '0;
    logic             cm_srca_vld = 1'b0;
    logic [4:0]       cm_srca = '0;
    logic             cm_srcb_vld = 1'b0;
    logic [4:0]       cm_srcb = '0;
    logic             cand_trig = 1'b0;
    logic             busy;
    logic             slice_valid;
    logic [4:0]       slice_cnt;
    logic [31:0]      slice_lead_pc;
    logic [MAXS*IW-1:0] slice_insn;
    logic [15:0]      drop_cnt;

    always #4 clk = ~clk;

    slice_extractor #(.N(N), .NREG(NREG), .PCW(PCW), .IW(IW), .MAXS(MAXS)) u0 (
        .clk(clk), .rst(rst), .cm_valid(cm_valid), .cm_pc(cm_pc), .cm_insn(cm_insn),
        .cm_class(cm_class), .cm_dst_vld(cm_dst_vld), .cm_dst(cm_dst),
        .cm_srca_vld(cm_srca_vld), .cm_srca(cm_srca), .cm_srcb_vld(cm_srcb_vld),
        .cm_srcb(cm_srcb), .cand_trig(cand_trig), .busy(busy), .slice_valid(slice_valid),
        .slice_cnt(slice_cnt), .slice_lead_pc(slice_lead_pc), .slice_insn(slice_insn),
        .drop_cnt(drop_cnt)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // model window
    logic [31:0] m_pc [N];
    logic [31:0] m_insn [N];
    logic [4:0]  m_d [N];
    logic        m_dv [N];
    logic [4:0]  m_a [N];
    logic        m_av [N];
    logic [4:0]  m_b [N];
    logic        m_bv [N];
    int m_n = 0;
    int m_wp = 0;
    int seq = 0;

    // expected slice
    bit           pending = 0;
    int           trig_cyc = 0;
    int           exp_cnt = 0;
    logic [31:0]  exp_lead = '0;
    logic [MAXS*IW-1:0] exp_flat = '0;
    int           exp_drop = 0;
    string        cur_req = "R3";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_slice();
        logic [31:0] live;
        int          sel_idx [MAXS];
        int          ns;
        int          e;
        int          newest;
        newest = (m_wp + N - 1) % N;
        live = '0;
        ns = 0;
        sel_idx[0] = newest;
        ns = 1;
        if (m_av[newest]) live[m_a[newest]] = 1'b1;
        if (m_bv[newest]) live[m_b[newest]] = 1'b1;
        for (int j = 1; j < m_n; j++) begin
            e = (newest + N - j) % N;
            if (m_dv[e] && live[m_d[e]]) begin
                live[m_d[e]] = 1'b0;
                if (m_av[e]) live[m_a[e]] = 1'b1;
                if (m_bv[e]) live[m_b[e]] = 1'b1;
                if (ns < MAXS) sel_idx[ns] = e;
                ns++;
            end
        end
        if (ns > MAXS) ns = MAXS;
        exp_cnt = ns;
        exp_flat = '0;
        for (int i = 0; i < ns; i++) exp_flat[i*IW +: IW] = m_insn[sel_idx[ns-1-i]];
        exp_lead = m_pc[sel_idx[ns-1]];
    endtask

    task automatic commit(input logic [2:0] cls, input bit dv, input int d,
                          input bit av, input int a, input bit bv, input int b,
                          input bit trig);
        bit exp_busy;
        @(negedge clk);
        seq++;
        cm_valid = 1'b1;
        cm_pc = 32'h0040_0000 + 32'(seq * 4);
        cm_insn = 32'h5A00_0000 | 32'(seq);
        cm_class = cls;
        cm_dst_vld = dv; cm_dst = 5'(d);
        cm_srca_vld = av; cm_srca = 5'(a);
        cm_srcb_vld = bv; cm_srcb = 5'(b);
        cand_trig = trig;
        if (cls == 3'd0 || cls == 3'd1) begin
            m_pc[m_wp] = cm_pc; m_insn[m_wp] = cm_insn;
            m_dv[m_wp] = dv; m_d[m_wp] = 5'(d);
            m_av[m_wp] = av; m_a[m_wp] = 5'(a);
            m_bv[m_wp] = bv; m_b[m_wp] = 5'(b);
            m_wp = (m_wp + 1) % N;
            if (m_n < N) m_n++;
        end
        exp_busy = pending && (cyc > trig_cyc) && (cyc <= trig_cyc + N + 2);
        if (trig && cls == 3'd1) begin
            if (exp_busy) exp_drop++;
            else begin
                model_slice();
                trig_cyc = cyc;
                pending = 1;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cm_valid = 1'b0;
            cand_trig = 1'b0;
        end
    endtask

    task automatic wait_done();
        int lim;
        lim = 0;
        while (pending && lim < 200) begin
            idle(1);
            lim++;
        end
        idle(1);
    endtask

    // Output monitor: sampled on falling edges, away from the active edge.
    always @(negedge clk) begin
        if (!rst && pending) begin
            if (cyc == trig_cyc + 1)
                chk(busy === 1'b1, "R7", "busy after trigger", 64'(busy), 64'd1);
            if (slice_valid) begin
                chk(cyc == trig_cyc + N + 3, "R7", "slice latency", 64'(cyc - trig_cyc - 1), 64'(N + 2));
                chk(busy === 1'b0, "R7", "busy with slice_valid", 64'(busy), 64'd0);
                chk(slice_cnt == 5'(exp_cnt), cur_req, "slice_cnt", 64'(slice_cnt), 64'(exp_cnt));
                chk(slice_lead_pc == exp_lead, "R5", "lead pc", 64'(slice_lead_pc), 64'(exp_lead));
                chk(slice_insn == exp_flat, cur_req, "slice words (R5 order)",
                    64'(slice_insn[63:0]), 64'(exp_flat[63:0]));
                pending = 0;
            end else if (cyc > trig_cyc + N + 3) begin
                chk(1'b0, "R7", "slice_valid missing", 64'd0, 64'd1);
                pending = 0;
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
        chk(slice_valid == 1'b0, "R1", "slice_valid", 64'(slice_valid), 64'd0);
        chk(slice_cnt == 5'd0, "R1", "slice_cnt", 64'(slice_cnt), 64'd0);
        chk(drop_cnt == 16'd0, "R1", "drop_cnt", 64'(drop_cnt), 64'd0);

        // R3 pointer chase: load r1<-[r1]; load r2<-[r1]; branch; alu r2<-r2,r4
        cur_req = "R3";
        for (int it = 0; it < 3; it++) begin
            commit(3'd1, 1, 1, 1, 1, 0, 0, 0);
            commit(3'd1, 1, 2, 1, 1, 0, 0, 0);
            commit(3'd3, 0, 0, 1, 2, 1, 5, 0);
            commit(3'd0, 1, 2, 1, 2, 1, 4, 0);
        end
        commit(3'd1, 1, 1, 1, 1, 0, 0, 1);
        wait_done();

        // R10 trigger on a non-load is ignored
        commit(3'd0, 1, 9, 0, 0, 0, 0, 1);
        idle(1);
        chk(busy == 1'b0, "R10", "busy after ALU trigger", 64'(busy), 64'd0);
        chk(drop_cnt == 16'(exp_drop), "R10", "drop_cnt", 64'(drop_cnt), 64'(exp_drop));

        // R2 non-address classes interleaved beyond window size
        cur_req = "R2";
        commit(3'd0, 1, 10, 0, 0, 0, 0, 0);
        for (int i = 0; i < 45; i++) commit(3'(2 + (i % 3)), 1, 10, 1, 10, 0, 0, 0);
        commit(3'd0, 1, 11, 1, 10, 0, 0, 0);
        for (int i = 0; i < 20; i++) commit(3'd2, 0, 0, 1, 11, 0, 0, 0);
        commit(3'd1, 1, 12, 1, 11, 0, 0, 1);
        wait_done();

        // R6 chain of 20 dependent ALU ops capped at 16
        cur_req = "R6";
        commit(3'd0, 1, 3, 0, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) commit(3'd0, 1, 3, 1, 3, 1, 5, 0);
        commit(3'd1, 1, 6, 1, 3, 0, 0, 1);
        wait_done();

        // R4 producer pushed out of the window
        cur_req = "R4";
        commit(3'd0, 1, 8, 0, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) commit(3'd0, 1, 9, 1, 7, 0, 0, 0);
        commit(3'd1, 1, 13, 1, 8, 1, 9, 1);
        wait_done();

        // R8 / R9 commits and a dropped trigger during a walk
        cur_req = "R8";
        commit(3'd0, 1, 14, 0, 0, 0, 0, 0);
        commit(3'd1, 1, 15, 1, 14, 0, 0, 1);
        commit(3'd0, 1, 14, 1, 15, 0, 0, 0);
        commit(3'd1, 1, 16, 1, 14, 0, 0, 1);
        for (int i = 0; i < 5; i++) commit(3'd0, 1, 17, 1, 16, 0, 0, 0);
        idle(1);
        chk(drop_cnt == 16'(exp_drop), "R9", "drop_cnt after busy trigger", 64'(drop_cnt), 64'(exp_drop));
        wait_done();
        commit(3'd1, 1, 18, 1, 17, 0, 0, 1);
        wait_done();

        // R3 near-exhaustive sweep with a small register set
        cur_req = "R3";
        for (int r = 0; r < 40; r++) begin
            int len;
            len = 3 + int'($urandom_range(0, 45));
            for (int i = 0; i < len; i++) begin
                commit(3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), int'($urandom_range(1, 4)),
                       1'($urandom_range(0, 1)), int'($urandom_range(1, 4)),
                       1'($urandom_range(0, 1)), int'($urandom_range(1, 4)), 0);
            end
            commit(3'd1, 1, int'($urandom_range(1, 4)), 1, int'($urandom_range(1, 4)),
                   1'($urandom_range(0, 1)), int'($urandom_range(1, 4)), 1);
            wait_done();
        end

        chk(drop_cnt == 16'(exp_drop), "R9", "final drop_cnt", 64'(drop_cnt), 64'(exp_drop));
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule